// File: doc/BRIEF.md
# Reservation Station Issue Pool

This block holds instructions that have been dispatched but cannot yet run because one or both source operands are still being computed. Each held entry records an operation code, a destination tag, and two operand slots. Each operand slot holds either a value or the tag of the result it is waiting for. Every cycle, the entries watch a single result broadcast bus. Any slot whose pending tag matches the broadcast tag takes the broadcast value.

An entry whose two operands are both present is ready. When the single functional unit downstream reports that it is free, the pool sends out one ready entry. It picks the entry with the lowest index, not the oldest one. The entry is released in the same cycle, so instructions can leave in an order unrelated to their arrival. Dispatch pauses while every entry is occupied.

Top module: `rs_pool`

## Requirements
- R1: After reset no entry is occupied, `iss_valid` is 0 and `disp_ready` is 1.
- R2: A dispatch is accepted on a clock edge where `disp_valid` and `disp_ready` are both 1, and it fills the lowest-index free entry. `disp_ready` is 0 exactly while all NENT entries are occupied.
- R3: An operand presented with its valid flag set at dispatch is stored as given and is never replaced by a broadcast.
- R4: In an occupied entry, a pending operand takes `cdb_data` on an edge where `cdb_valid` is 1 and `cdb_tag` equals its stored tag. A broadcast with a different tag leaves the operand pending, so the entry does not issue.
- R5: A broadcast on the same edge as the dispatch is captured by the newly written entry when its tag matches that entry's pending source tag.
- R6: An entry with both operands present issues on an edge where `fu_free` is 1. At most one entry issues per edge. In the following cycle `iss_valid` is 1 and the issue port shows the entry's operation, its first operand on `iss_a`, its second operand on `iss_b`, and its destination tag. When nothing issued on the previous edge, `iss_valid` is 0.
- R7: On an edge where `fu_free` is 0 nothing issues, and `iss_valid` is 0 in the following cycle.
- R8: When several entries are ready, the one with the lowest index issues first, whatever order they arrived in.
- R9: An issuing entry becomes free on the same edge, so `disp_ready` rises again and the entry can be refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Pool can accept a dispatch |
| disp_op | input | OPW | Operation code |
| disp_t1 | input | TAGW | First source tag |
| disp_v1 | input | 1 | First operand already present |
| disp_d1 | input | DATW | First operand value |
| disp_t2 | input | TAGW | Second source tag |
| disp_v2 | input | 1 | Second operand already present |
| disp_d2 | input | DATW | Second operand value |
| disp_dst | input | TAGW | Destination tag |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAGW | Result broadcast tag |
| cdb_data | input | DATW | Result broadcast value |
| fu_free | input | 1 | Functional unit can accept an instruction |
| iss_valid | output | 1 | Issue strobe (registered) |
| iss_op | output | OPW | Issued operation |
| iss_a | output | DATW | Issued first operand |
| iss_b | output | DATW | Issued second operand |
| iss_dst | output | TAGW | Issued destination tag |

## Verification
The hardest state to reach from the ports is one where the order of arrival and the order of entry index disagree. Reaching it needs an old instruction still waiting in a high entry while newer ones fill the low entries that have just been freed, followed by a single broadcast that wakes entries of both ages at once. The stimulus gets there in several steps:
- It holds `fu_free` low while all four entries fill with a mix of ready and waiting instructions.
- It drains the ready entries, leaving one old entry waiting.
- It refills the freed low entries, including one that waits on the same tag as the old entry.
- It releases the shared tag, so the low-index newcomers must leave first.

A sweep over every pair of dispatch-time operand valid flags, each with a matching and a non-matching broadcast in the same cycle, covers capture at the moment of dispatch.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_ENTRIES = 4;
  localparam int RS_OPW     = 4;
  localparam int RS_TAGW    = 4;
  localparam int RS_DATW    = 16;
endpackage

// File: rtl/rs_operand.sv
// One source operand slot: holds either a value or the tag it is waiting for.
module rs_operand #(
  parameter int TAGW = 4,
  parameter int DATW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            live,
  input  logic [TAGW-1:0] in_tag,
  input  logic            in_vld,
  input  logic [DATW-1:0] in_data,
  input  logic            bc_valid,
  input  logic [TAGW-1:0] bc_tag,
  input  logic [DATW-1:0] bc_data,
  output logic            vld,
  output logic [DATW-1:0] data
);
  logic [TAGW-1:0] tag_q;
  logic            hit_new, hit_old;

  assign hit_new = bc_valid && (bc_tag == in_tag);
  assign hit_old = live && !vld && bc_valid && (bc_tag == tag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else if (load) begin
      tag_q <= in_tag;
      if (in_vld) begin
        vld  <= 1'b1;
        data <= in_data;
      end else if (hit_new) begin
        vld  <= 1'b1;
        data <= bc_data;
      end else begin
        vld  <= 1'b0;
      end
    end else if (hit_old) begin
      vld  <= 1'b1;
      data <= bc_data;
    end
  end
endmodule

// File: rtl/rs_slot.sv
// One station entry: occupancy, op, destination and two operand slots.
module rs_slot #(
  parameter int OPW  = 4,
  parameter int TAGW = 4,
  parameter int DATW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc,
  input  logic            release_i,
  input  logic [OPW-1:0]  in_op,
  input  logic [TAGW-1:0] in_t1,
  input  logic            in_v1,
  input  logic [DATW-1:0] in_d1,
  input  logic [TAGW-1:0] in_t2,
  input  logic            in_v2,
  input  logic [DATW-1:0] in_d2,
  input  logic [TAGW-1:0] in_dst,
  input  logic            bc_valid,
  input  logic [TAGW-1:0] bc_tag,
  input  logic [DATW-1:0] bc_data,
  output logic            busy,
  output logic            ready,
  output logic [OPW-1:0]  op,
  output logic [DATW-1:0] d1,
  output logic [DATW-1:0] d2,
  output logic [TAGW-1:0] dst
);
  logic v1, v2;

  always_ff @(posedge clk) begin
    if (rst)            busy <= 1'b0;
    else if (alloc)     busy <= 1'b1;
    else if (release_i) busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      op  <= in_op;
      dst <= in_dst;
    end
  end

  rs_operand #(.TAGW(TAGW), .DATW(DATW)) src1_i (
    .clk(clk), .rst(rst), .load(alloc), .live(busy),
    .in_tag(in_t1), .in_vld(in_v1), .in_data(in_d1),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .vld(v1), .data(d1));

  rs_operand #(.TAGW(TAGW), .DATW(DATW)) src2_i (
    .clk(clk), .rst(rst), .load(alloc), .live(busy),
    .in_tag(in_t2), .in_vld(in_v2), .in_data(in_d2),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .vld(v2), .data(d2));

  assign ready = busy && v1 && v2;
endmodule

// File: rtl/rs_pick.sv
// Lowest-index one-hot picker.
module rs_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
  assign any = seen[N];
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int NENT = rs_pkg::RS_ENTRIES,
  parameter int OPW  = rs_pkg::RS_OPW,
  parameter int TAGW = rs_pkg::RS_TAGW,
  parameter int DATW = rs_pkg::RS_DATW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            disp_valid,
  output logic            disp_ready,
  input  logic [OPW-1:0]  disp_op,
  input  logic [TAGW-1:0] disp_t1,
  input  logic            disp_v1,
  input  logic [DATW-1:0] disp_d1,
  input  logic [TAGW-1:0] disp_t2,
  input  logic            disp_v2,
  input  logic [DATW-1:0] disp_d2,
  input  logic [TAGW-1:0] disp_dst,
  input  logic            cdb_valid,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [DATW-1:0] cdb_data,
  input  logic            fu_free,
  output logic            iss_valid,
  output logic [OPW-1:0]  iss_op,
  output logic [DATW-1:0] iss_a,
  output logic [DATW-1:0] iss_b,
  output logic [TAGW-1:0] iss_dst
);
  logic [NENT-1:0] busy_w, ready_w, grant_w, free_grant, alloc_w, release_w;
  logic            any_ready, any_free, fire_w, take_w;
  logic [OPW-1:0]  s_op  [NENT];
  logic [DATW-1:0] s_d1  [NENT];
  logic [DATW-1:0] s_d2  [NENT];
  logic [TAGW-1:0] s_dst [NENT];
  logic [OPW-1:0]  m_op;
  logic [DATW-1:0] m_a, m_b;
  logic [TAGW-1:0] m_dst;

  rs_pick #(.N(NENT)) issue_pick_i (.req(ready_w), .grant(grant_w), .any(any_ready));
  rs_pick #(.N(NENT)) alloc_pick_i (.req(~busy_w), .grant(free_grant), .any(any_free));

  assign disp_ready = any_free;
  assign take_w     = disp_valid && any_free;
  assign fire_w     = fu_free && any_ready;
  assign alloc_w    = free_grant & {NENT{take_w}};
  assign release_w  = grant_w & {NENT{fu_free}};

  for (genvar i = 0; i < NENT; i++) begin : g_slot
    rs_slot #(.OPW(OPW), .TAGW(TAGW), .DATW(DATW)) slot_i (
      .clk(clk), .rst(rst), .alloc(alloc_w[i]), .release_i(release_w[i]),
      .in_op(disp_op), .in_t1(disp_t1), .in_v1(disp_v1), .in_d1(disp_d1),
      .in_t2(disp_t2), .in_v2(disp_v2), .in_d2(disp_d2), .in_dst(disp_dst),
      .bc_valid(cdb_valid), .bc_tag(cdb_tag), .bc_data(cdb_data),
      .busy(busy_w[i]), .ready(ready_w[i]),
      .op(s_op[i]), .d1(s_d1[i]), .d2(s_d2[i]), .dst(s_dst[i]));
  end

  always_comb begin
    m_op  = '0;
    m_a   = '0;
    m_b   = '0;
    m_dst = '0;
    for (int i = 0; i < NENT; i++) begin
      if (grant_w[i]) begin
        m_op  = m_op  | s_op[i];
        m_a   = m_a   | s_d1[i];
        m_b   = m_b   | s_d2[i];
        m_dst = m_dst | s_dst[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) iss_valid <= 1'b0;
    else     iss_valid <= fire_w;
  end

  always_ff @(posedge clk) begin
    if (fire_w) begin
      iss_op  <= m_op;
      iss_a   <= m_a;
      iss_b   <= m_b;
      iss_dst <= m_dst;
    end
  end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int NENT = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NENT-1:0] busy,
  input logic [NENT-1:0] ready,
  input logic [NENT-1:0] grant,
  input logic            fu_free,
  input logic            iss_valid,
  input logic            disp_valid,
  input logic            disp_ready
);
  AST_HOLD_WHEN_UNIT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !fu_free |=> !iss_valid); // R7

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R6

  AST_GRANT_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    (grant & ~ready) == '0); // R6

  AST_ISSUE_NEEDS_UNIT: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> $past(fu_free)); // R6

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> ((ready & (grant - 1'b1)) == '0)); // R8

  AST_FREE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (fu_free && (|grant)) |=> ((busy & $past(grant)) == '0)); // R9

  AST_FILL_COUNT: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready && !(fu_free && (|grant)))
      |=> ($countones(busy) == $past($countones(busy)) + 1)); // R2
endmodule

bind rs_pool rs_pool_chk #(.NENT(NENT)) chk_i (
  .clk(clk), .rst(rst), .busy(busy_w), .ready(ready_w), .grant(grant_w),
  .fu_free(fu_free), .iss_valid(iss_valid), .disp_valid(disp_valid),
  .disp_ready(disp_ready));

// File: tb/rs_pool_tb_top.sv
module rs_pool_tb_top;
  localparam int NENT = 4, OPW = 4, TAGW = 4, DATW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic            disp_valid, disp_ready, disp_v1, disp_v2;
  logic [OPW-1:0]  disp_op;
  logic [TAGW-1:0] disp_t1, disp_t2, disp_dst;
  logic [DATW-1:0] disp_d1, disp_d2;
  logic            cdb_valid, fu_free, iss_valid;
  logic [TAGW-1:0] cdb_tag, iss_dst;
  logic [DATW-1:0] cdb_data, iss_a, iss_b;
  logic [OPW-1:0]  iss_op;

  rs_pool #(.NENT(NENT), .OPW(OPW), .TAGW(TAGW), .DATW(DATW)) dut_i (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_op(disp_op), .disp_t1(disp_t1), .disp_v1(disp_v1), .disp_d1(disp_d1),
    .disp_t2(disp_t2), .disp_v2(disp_v2), .disp_d2(disp_d2), .disp_dst(disp_dst),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .fu_free(fu_free), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .iss_dst(iss_dst));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [OPW-1:0] op, input logic [TAGW-1:0] t1, input logic v1,
                     input logic [DATW-1:0] d1, input logic [TAGW-1:0] t2, input logic v2,
                     input logic [DATW-1:0] d2, input logic [TAGW-1:0] dst);
    disp_valid = 1'b1; disp_op = op;
    disp_t1 = t1; disp_v1 = v1; disp_d1 = d1;
    disp_t2 = t2; disp_v2 = v2; disp_d2 = d2;
    disp_dst = dst;
  endtask

  task automatic bcast(input logic [TAGW-1:0] t, input logic [DATW-1:0] d);
    cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
  endtask

  task automatic issue_is(input string req, input logic [OPW-1:0] op, input logic [DATW-1:0] a,
                          input logic [DATW-1:0] b, input logic [TAGW-1:0] dst);
    chk(iss_valid == 1'b1, req, 64'(iss_valid), 64'd1);
    chk({iss_op, iss_a, iss_b, iss_dst} == {op, a, b, dst}, req,
        64'({iss_op, iss_a, iss_b, iss_dst}), 64'({op, a, b, dst}));
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    disp_valid = 0; disp_op = 0; disp_t1 = 0; disp_v1 = 0; disp_d1 = 0;
    disp_t2 = 0; disp_v2 = 0; disp_d2 = 0; disp_dst = 0;
    cdb_valid = 0; cdb_tag = 0; cdb_data = 0; fu_free = 0;
    repeat (3) nx();
    rst = 1'b0;
    nx();
    // R1 reset state
    chk(iss_valid == 1'b0, "R1 iss_valid", 64'(iss_valid), 64'd0);
    chk(disp_ready == 1'b1, "R1 disp_ready", 64'(disp_ready), 64'd1);

    // Sweep of dispatch-time valid flags against matching / other-tag broadcast (R3 R4 R5)
    fu_free = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 2; m++) begin
        bit v1, v2, waits;
        logic [DATW-1:0] d1, d2, late, ea, eb;
        v1 = p[0]; v2 = p[1];
        d1 = 16'h1000 + 16'(p); d2 = 16'h2000 + 16'(p);
        late = (m == 1) ? 16'h4000 + 16'(p) : 16'h6000;
        waits = !(v1 && v2) && (m == 0);
        ea = v1 ? d1 : late;
        eb = v2 ? d2 : late;
        put(4'(p * 2 + m), 4'd3, v1, d1, 4'd3, v2, d2, 4'd9);
        if (m == 1) bcast(4'd3, 16'h4000 + 16'(p));
        else        bcast(4'd4, 16'h4000 + 16'(p));
        nx();
        disp_valid = 1'b0;
        if (waits) bcast(4'd3, 16'h6000);
        else       cdb_valid = 1'b0;
        nx();
        cdb_valid = 1'b0;
        if (!waits) begin
          issue_is(m == 1 ? "R5 same-cycle capture" : "R3 stored operands", 4'(p * 2 + m), ea, eb, 4'd9);
        end else begin
          chk(iss_valid == 1'b0, "R4 other tag ignored", 64'(iss_valid), 64'd0);
          nx();
          issue_is("R4 later capture", 4'(p * 2 + m), ea, eb, 4'd9);
        end
        nx();
        chk(iss_valid == 1'b0, "R6 one issue only", 64'(iss_valid), 64'd0);
      end
    end

    // Fill the pool while the unit is held (R2 R7)
    fu_free = 1'b0;
    put(4'd1, 4'd7, 1'b0, 16'h0, 4'd0, 1'b1, 16'h0B00, 4'd1); nx();
    put(4'd2, 4'd0, 1'b1, 16'h0A01, 4'd0, 1'b1, 16'h0B01, 4'd2); nx();
    chk(disp_ready == 1'b1, "R2 ready with free entries", 64'(disp_ready), 64'd1);
    put(4'd3, 4'd0, 1'b1, 16'h0A02, 4'd8, 1'b0, 16'h0, 4'd3); nx();
    put(4'd4, 4'd0, 1'b1, 16'h0A03, 4'd0, 1'b1, 16'h0B03, 4'd4); nx();
    disp_valid = 1'b0;
    chk(disp_ready == 1'b0, "R2 full stall", 64'(disp_ready), 64'd0);
    chk(iss_valid == 1'b0, "R7 held unit", 64'(iss_valid), 64'd0);
    bcast(4'd7, 16'h0777); nx();
    cdb_valid = 1'b0; nx(); nx();
    chk(iss_valid == 1'b0, "R7 ready entries held", 64'(iss_valid), 64'd0);
    chk(disp_ready == 1'b0, "R2 still full", 64'(disp_ready), 64'd0);

    // Release the unit: lowest index first, waiting entry skipped (R8 R9)
    fu_free = 1'b1; nx();
    issue_is("R8 entry0", 4'd1, 16'h0777, 16'h0B00, 4'd1);
    chk(disp_ready == 1'b1, "R9 freed on issue", 64'(disp_ready), 64'd1);
    nx();
    issue_is("R8 entry1", 4'd2, 16'h0A01, 16'h0B01, 4'd2);
    nx();
    issue_is("R8 entry3 passes waiting entry2", 4'd4, 16'h0A03, 16'h0B03, 4'd4);
    bcast(4'd9, 16'hDEAD); nx();
    cdb_valid = 1'b0;
    chk(iss_valid == 1'b0, "R4 wrong tag no wake", 64'(iss_valid), 64'd0);
    nx();
    chk(iss_valid == 1'b0, "R4 still waiting", 64'(iss_valid), 64'd0);

    // Refill freed low entries; shared wakeup puts newer low entries first (R2 R8 R9)
    fu_free = 1'b0;
    put(4'd5, 4'd0, 1'b1, 16'h0A05, 4'd0, 1'b1, 16'h0B05, 4'd5); nx();
    put(4'd6, 4'd8, 1'b0, 16'h0, 4'd0, 1'b1, 16'h0B06, 4'd6); nx();
    disp_valid = 1'b0;
    bcast(4'd8, 16'h0888); nx();
    cdb_valid = 1'b0;
    fu_free = 1'b1; nx();
    issue_is("R9 reused entry0", 4'd5, 16'h0A05, 16'h0B05, 4'd5);
    nx();
    issue_is("R8 newer entry1 first", 4'd6, 16'h0888, 16'h0B06, 4'd6);
    nx();
    issue_is("R8 old entry2 last", 4'd3, 16'h0A02, 16'h0888, 4'd3);
    nx();
    chk(iss_valid == 1'b0, "R6 drained", 64'(iss_valid), 64'd0);
    chk(disp_ready == 1'b1, "R9 all free", 64'(disp_ready), 64'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule